// File: doc/BRIEF.md
# Fence Slot LRU Allocator

This block manages a small fixed pool of address-fence slots and hands them out to requesting objects, each known by an object ID. A client issues one command per cycle: get, put, pin, unpin or mark-dirty. The block keeps, for every slot, its owner, a pin count, a dirty flag and a recency age. It answers each command one cycle later with a done strobe, a result code, the slot concerned and a set of flags.

A get for a tiled object that holds no slot takes the lowest-numbered empty slot. When every slot is occupied, the get reclaims the least recently used slot whose pin count is zero. It also reports that the previous owner has lost its fence. If every slot is occupied and pinned, the request fails. The failure code is a retry when a display flip is still pending, and a deadlock otherwise.

Writing the fence contents into hardware and waiting for outstanding work are left to the surrounding logic. The program flag tells that logic when a slot has to be written. Pins guard slots that scan-out is using, and the dirty mark forces a slot to be rewritten after the object's tiling has changed.

Top module: `fence_slot_alloc`

## Requirements
- R1: A command presented with `cmd_valid` high produces `rsp_done` high on exactly the next clock cycle. `rsp_done` is low in every cycle that follows a cycle without a command. Opcodes are: get=0, put=1, pin=2, unpin=3, mark-dirty=4. Opcodes 5 to 7 answer OK (code 0) and change nothing. After reset no slot is owned.
- R2: A get with `cmd_tiled`=1 from an object that owns no slot, when some slot is empty, grants the lowest-indexed empty slot. It answers with code OK=0, fence=1 and program=1. No two slots ever share an owner.
- R3: When a tiled get from an object that owns no slot finds no empty slot, it grants the least recently used slot that has a zero pin count. It answers with evict=1 and `rsp_victim` set to the previous owner. Recency is refreshed by every grant and every get that hits.
- R4: When all slots are occupied and pinned, a tiled get from an object that owns no slot changes nothing. It answers with fence=0 and program=0. The code is RETRY=3 if `flip_pending` is high and DEADLOCK=2 otherwise.
- R5: A get from an object that owns a clean slot returns that slot with fence=1 and program=0, whatever the value of `cmd_tiled`. The slot becomes the most recently used.
- R6: A get with `cmd_tiled`=0 from an object that owns no slot answers OK with fence=0 and program=0, and claims no slot.
- R7: A put on an owned slot with a nonzero pin count answers BUSY=1 with fence=1 and keeps the slot. A put on an owned slot with a zero pin count frees the slot and answers program=1 and fence=0. A put from an object that owns nothing answers OK.
- R8: A pin on an owned slot raises its pin count and answers fence=1. A pin from an object that owns nothing answers fence=0. When the count is already at its maximum of 2^PIN_W-1, the pin answers BUSY and leaves the count unchanged.
- R9: An unpin lowers the pin count of an owned slot. An unpin on a count of zero answers UNDERFLOW=4 and leaves the slot unchanged.
- R10: A mark-dirty sets a flag on the owned slot. The next get from that owner then answers program=1 instead of a plain recency update: with `cmd_tiled`=1 it keeps the slot with fence=1, and with `cmd_tiled`=0 it frees the slot with fence=0. That get clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode (get=0, put=1, pin=2, unpin=3, mark-dirty=4) |
| cmd_obj | input | OBJ_W | Requesting object ID |
| cmd_tiled | input | 1 | Object is tiled and wants a fence |
| flip_pending | input | 1 | A display flip still holds fences |
| rsp_done | output | 1 | Response strobe, one cycle after the command |
| rsp_code | output | 3 | Result: OK=0, BUSY=1, DEADLOCK=2, RETRY=3, UNDERFLOW=4 |
| rsp_slot | output | SLOT_W | Slot concerned when fence or program is set, else 0 |
| rsp_fence | output | 1 | Object owns a slot after the command |
| rsp_prog | output | 1 | Slot contents must be (re)written |
| rsp_evict | output | 1 | Previous owner of the slot lost its fence |
| rsp_victim | output | OBJ_W | Previous owner when evict is set, else 0 |

## Verification
The hardest state to reach is a full pool in which the least recently used slot is pinned. In that state eviction must pass over the oldest slot to reach a younger one. Getting there takes a scripted sequence: fill every slot, refresh one of them by a repeated get, and pin the oldest. Only then is the pool pinned completely, which exposes both the retry and the deadlock outcomes. After the scripted part, a long random run over a small set of object IDs keeps the pool under constant pressure from interleaved pins, puts and dirty marks. Every response is compared with a behavioural model that keeps recency as an ordered queue.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    typedef enum logic [2:0] {
        OP_GET   = 3'd0,
        OP_PUT   = 3'd1,
        OP_PIN   = 3'd2,
        OP_UNPIN = 3'd3,
        OP_MARK  = 3'd4
    } fsa_op_e;

    typedef enum logic [2:0] {
        RC_OK        = 3'd0,
        RC_BUSY      = 3'd1,
        RC_DEADLOCK  = 3'd2,
        RC_RETRY     = 3'd3,
        RC_UNDERFLOW = 3'd4
    } fsa_rc_e;

    typedef struct packed {
        fsa_rc_e code;
        logic    fence;
        logic    prog;
        logic    evict;
    } fsa_flags_t;

    // Failure code when every slot is held by a pin.
    function automatic fsa_rc_e starve_code(input logic flip);
        return flip ? RC_RETRY : RC_DEADLOCK;
    endfunction

endpackage

// File: rtl/fsa_lookup.sv
// Combinational scan of the slot table: owner hit, lowest empty slot,
// oldest unpinned occupied slot.
module fsa_lookup #(
    parameter int N      = 4,
    parameter int OBJ_W  = 8,
    parameter int PIN_W  = 3,
    parameter int SLOT_W = 2
) (
    input  logic [N-1:0]      occ,
    input  logic [OBJ_W-1:0]  owner [N],
    input  logic [PIN_W-1:0]  pins  [N],
    input  logic [SLOT_W-1:0] age   [N],
    input  logic [OBJ_W-1:0]  obj,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_idx,
    output logic              free_found,
    output logic [SLOT_W-1:0] free_idx,
    output logic              vict_found,
    output logic [SLOT_W-1:0] vict_idx
);
    logic [SLOT_W-1:0] best_age;

    always_comb begin
        hit        = 1'b0;
        hit_idx    = '0;
        free_found = 1'b0;
        free_idx   = '0;
        vict_found = 1'b0;
        vict_idx   = '0;
        best_age   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                free_found = 1'b1;
                free_idx   = SLOT_W'(i);
            end
        end
        for (int i = 0; i < N; i++) begin
            if (occ[i] && owner[i] == obj) begin
                hit     = 1'b1;
                hit_idx = SLOT_W'(i);
            end
            if (occ[i] && pins[i] == '0 && (!vict_found || age[i] > best_age)) begin
                vict_found = 1'b1;
                vict_idx   = SLOT_W'(i);
                best_age   = age[i];
            end
        end
    end
endmodule

// File: rtl/fsa_recency.sv
// Per-slot age counters: 0 is most recent, occupied slots hold distinct ages.
module fsa_recency #(
    parameter int N      = 4,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      occ,
    input  logic              touch,
    input  logic              touch_fresh,
    input  logic [SLOT_W-1:0] touch_idx,
    input  logic              drop,
    input  logic [SLOT_W-1:0] drop_idx,
    output logic [SLOT_W-1:0] age [N]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < N; j++) age[j] <= '0;
        end else if (touch) begin
            for (int j = 0; j < N; j++) begin
                if (SLOT_W'(j) == touch_idx)
                    age[j] <= '0;
                else if (occ[j] && (touch_fresh || age[j] < age[touch_idx]))
                    age[j] <= age[j] + 1'b1;
            end
        end else if (drop) begin
            for (int j = 0; j < N; j++) begin
                if (SLOT_W'(j) == drop_idx)
                    age[j] <= '0;
                else if (occ[j] && age[j] > age[drop_idx])
                    age[j] <= age[j] - 1'b1;
            end
        end
    end
endmodule

// File: rtl/fence_slot_alloc.sv
module fence_slot_alloc
    import fsa_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int OBJ_W     = 8,
    parameter int PIN_W     = 3,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [OBJ_W-1:0]  cmd_obj,
    input  logic              cmd_tiled,
    input  logic              flip_pending,
    output logic              rsp_done,
    output logic [2:0]        rsp_code,
    output logic [SLOT_W-1:0] rsp_slot,
    output logic              rsp_fence,
    output logic              rsp_prog,
    output logic              rsp_evict,
    output logic [OBJ_W-1:0]  rsp_victim
);
    localparam logic [PIN_W-1:0] PIN_MAX = {PIN_W{1'b1}};

    logic [NUM_SLOTS-1:0] occ_q, dirty_q;
    logic [OBJ_W-1:0]     own_q [NUM_SLOTS];
    logic [PIN_W-1:0]     pin_q [NUM_SLOTS];
    logic [SLOT_W-1:0]    age   [NUM_SLOTS];

    logic              hit, free_found, vict_found;
    logic [SLOT_W-1:0] hit_idx, free_idx, vict_idx;

    fsa_flags_t        nf;
    logic [SLOT_W-1:0] n_slot;
    logic [OBJ_W-1:0]  n_victim;
    logic              claim, rel, pin_up, pin_dn, dset, dclr;
    logic              touch, touch_fresh;
    logic [SLOT_W-1:0] claim_idx, touch_idx;

    fsa_lookup #(.N(NUM_SLOTS), .OBJ_W(OBJ_W), .PIN_W(PIN_W), .SLOT_W(SLOT_W)) u_lookup (
        .occ(occ_q), .owner(own_q), .pins(pin_q), .age(age), .obj(cmd_obj),
        .hit(hit), .hit_idx(hit_idx), .free_found(free_found), .free_idx(free_idx),
        .vict_found(vict_found), .vict_idx(vict_idx)
    );

    fsa_recency #(.N(NUM_SLOTS), .SLOT_W(SLOT_W)) u_recency (
        .clk(clk), .rst(rst), .occ(occ_q),
        .touch(touch), .touch_fresh(touch_fresh), .touch_idx(touch_idx),
        .drop(rel), .drop_idx(hit_idx), .age(age)
    );

    always_comb begin
        nf          = '{code: RC_OK, fence: 1'b0, prog: 1'b0, evict: 1'b0};
        n_slot      = '0;
        n_victim    = '0;
        claim       = 1'b0;
        claim_idx   = '0;
        rel         = 1'b0;
        pin_up      = 1'b0;
        pin_dn      = 1'b0;
        dset        = 1'b0;
        dclr        = 1'b0;
        touch       = 1'b0;
        touch_fresh = 1'b0;
        touch_idx   = '0;
        if (cmd_valid) begin
            case (fsa_op_e'(cmd_op))
                OP_GET: begin
                    if (hit) begin
                        n_slot = hit_idx;
                        if (!dirty_q[hit_idx] || cmd_tiled) begin
                            touch     = 1'b1;
                            touch_idx = hit_idx;
                            nf.fence  = 1'b1;
                            nf.prog   = dirty_q[hit_idx];
                            dclr      = dirty_q[hit_idx];
                        end else begin
                            rel     = 1'b1;
                            nf.prog = 1'b1;
                        end
                    end else if (cmd_tiled) begin
                        if (free_found || vict_found) begin
                            claim       = 1'b1;
                            claim_idx   = free_found ? free_idx : vict_idx;
                            touch       = 1'b1;
                            touch_fresh = free_found;
                            touch_idx   = claim_idx;
                            n_slot      = claim_idx;
                            nf.fence    = 1'b1;
                            nf.prog     = 1'b1;
                            nf.evict    = !free_found;
                            n_victim    = free_found ? '0 : own_q[vict_idx];
                        end else begin
                            nf.code = starve_code(flip_pending);
                        end
                    end
                end
                OP_PUT: begin
                    if (hit) begin
                        n_slot = hit_idx;
                        if (pin_q[hit_idx] != '0) begin
                            nf.code  = RC_BUSY;
                            nf.fence = 1'b1;
                        end else begin
                            rel     = 1'b1;
                            nf.prog = 1'b1;
                        end
                    end
                end
                OP_PIN: begin
                    if (hit) begin
                        n_slot   = hit_idx;
                        nf.fence = 1'b1;
                        if (pin_q[hit_idx] == PIN_MAX) nf.code = RC_BUSY;
                        else                           pin_up  = 1'b1;
                    end
                end
                OP_UNPIN: begin
                    if (hit) begin
                        n_slot   = hit_idx;
                        nf.fence = 1'b1;
                        if (pin_q[hit_idx] == '0) nf.code = RC_UNDERFLOW;
                        else                      pin_dn  = 1'b1;
                    end
                end
                OP_MARK: begin
                    if (hit) begin
                        n_slot   = hit_idx;
                        nf.fence = 1'b1;
                        dset     = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q      <= '0;
            dirty_q    <= '0;
            for (int j = 0; j < NUM_SLOTS; j++) begin
                own_q[j] <= '0;
                pin_q[j] <= '0;
            end
            rsp_done   <= 1'b0;
            rsp_code   <= '0;
            rsp_slot   <= '0;
            rsp_fence  <= 1'b0;
            rsp_prog   <= 1'b0;
            rsp_evict  <= 1'b0;
            rsp_victim <= '0;
        end else begin
            if (claim) begin
                occ_q[claim_idx]   <= 1'b1;
                own_q[claim_idx]   <= cmd_obj;
                pin_q[claim_idx]   <= '0;
                dirty_q[claim_idx] <= 1'b0;
            end
            if (rel) begin
                occ_q[hit_idx]   <= 1'b0;
                dirty_q[hit_idx] <= 1'b0;
            end
            if (pin_up) pin_q[hit_idx]   <= pin_q[hit_idx] + 1'b1;
            if (pin_dn) pin_q[hit_idx]   <= pin_q[hit_idx] - 1'b1;
            if (dset)   dirty_q[hit_idx] <= 1'b1;
            if (dclr)   dirty_q[hit_idx] <= 1'b0;
            rsp_done   <= cmd_valid;
            rsp_code   <= nf.code;
            rsp_slot   <= n_slot;
            rsp_fence  <= nf.fence;
            rsp_prog   <= nf.prog;
            rsp_evict  <= nf.evict;
            rsp_victim <= n_victim;
        end
    end
endmodule

// File: rtl/fence_slot_alloc_chk.sv
module fence_slot_alloc_chk
    import fsa_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int OBJ_W     = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic                 rsp_done,
    input logic [2:0]           rsp_code,
    input logic                 rsp_fence,
    input logic                 rsp_prog,
    input logic                 rsp_evict,
    input logic [NUM_SLOTS-1:0] occ,
    input logic [OBJ_W-1:0]     own [NUM_SLOTS]
);
    logic dup_owner;

    always_comb begin
        dup_owner = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++)
            for (int j = i + 1; j < NUM_SLOTS; j++)
                if (occ[i] && occ[j] && own[i] == own[j]) dup_owner = 1'b1;
    end

    AST_DONE_NEXT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_done); // R1
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_done); // R1
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        !dup_owner); // R2
    AST_EVICT_GRANTS: assert property (@(posedge clk) disable iff (rst)
        rsp_done && rsp_evict |-> rsp_fence && rsp_prog && rsp_code == RC_OK); // R3
    AST_STARVE_NO_FENCE: assert property (@(posedge clk) disable iff (rst)
        rsp_done && (rsp_code == RC_RETRY || rsp_code == RC_DEADLOCK)
        |-> !rsp_fence && !rsp_prog && !rsp_evict); // R4
    AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        rsp_done && rsp_code == RC_BUSY |-> rsp_fence && !rsp_prog); // R7
    AST_UNDERFLOW_KEEPS: assert property (@(posedge clk) disable iff (rst)
        rsp_done && rsp_code == RC_UNDERFLOW |-> rsp_fence && !rsp_prog); // R9
endmodule

bind fence_slot_alloc fence_slot_alloc_chk #(.NUM_SLOTS(NUM_SLOTS), .OBJ_W(OBJ_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .rsp_done(rsp_done),
    .rsp_code(rsp_code), .rsp_fence(rsp_fence), .rsp_prog(rsp_prog),
    .rsp_evict(rsp_evict), .occ(occ_q), .own(own_q)
);

// File: tb/fence_slot_alloc_tb.sv
module fence_slot_alloc_tb;
    localparam int N      = 4;
    localparam int OW     = 8;
    localparam int PW     = 3;
    localparam int SW     = 2;
    localparam int PMAX   = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [OW-1:0] cmd_obj = '0;
    logic          cmd_tiled = 1'b0;
    logic          flip_pending = 1'b0;
    logic          rsp_done, rsp_fence, rsp_prog, rsp_evict;
    logic [2:0]    rsp_code;
    logic [SW-1:0] rsp_slot;
    logic [OW-1:0] rsp_victim;

    always #4 clk = ~clk;

    fence_slot_alloc #(.NUM_SLOTS(N), .OBJ_W(OW), .PIN_W(PW)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_obj(cmd_obj), .cmd_tiled(cmd_tiled), .flip_pending(flip_pending),
        .rsp_done(rsp_done), .rsp_code(rsp_code), .rsp_slot(rsp_slot),
        .rsp_fence(rsp_fence), .rsp_prog(rsp_prog), .rsp_evict(rsp_evict),
        .rsp_victim(rsp_victim)
    );

    int checks = 0;
    int fails  = 0;

    // Behavioural reference: recency is an ordered queue, front = oldest.
    bit m_occ [N];
    int m_own [N];
    int m_pin [N];
    bit m_dirty [N];
    int lru [$];

    bit    e_valid;
    int    e_code, e_slot, e_fence, e_prog, e_evict, e_victim;
    string e_tag;

    function automatic int m_find(int obj);
        for (int i = 0; i < N; i++) if (m_occ[i] && m_own[i] == obj) return i;
        return -1;
    endfunction

    task automatic lru_remove(int s);
        for (int i = 0; i < lru.size(); i++)
            if (lru[i] == s) begin lru.delete(i); break; end
    endtask

    task automatic lru_touch(int s);
        lru_remove(s);
        lru.push_back(s);
    endtask

    task automatic m_free(int s);
        m_occ[s] = 0; m_dirty[s] = 0; m_pin[s] = 0;
        lru_remove(s);
    endtask

    task automatic model(int op, int obj, bit tiled, bit flip);
        int h;
        int f;
        int v;
        h = m_find(obj);
        e_code = 0; e_slot = 0; e_fence = 0; e_prog = 0; e_evict = 0; e_victim = 0;
        e_tag = "R1";
        case (op)
            0: begin
                if (h >= 0) begin
                    e_slot = h;
                    if (!m_dirty[h]) begin
                        e_tag = "R5"; e_fence = 1; lru_touch(h);
                    end else if (tiled) begin
                        e_tag = "R10"; e_fence = 1; e_prog = 1; m_dirty[h] = 0; lru_touch(h);
                    end else begin
                        e_tag = "R10"; e_prog = 1; m_free(h);
                    end
                end else if (!tiled) begin
                    e_tag = "R6";
                end else begin
                    f = -1;
                    for (int i = N - 1; i >= 0; i--) if (!m_occ[i]) f = i;
                    if (f >= 0) begin
                        e_tag = "R2";
                        m_occ[f] = 1; m_own[f] = obj; m_pin[f] = 0; m_dirty[f] = 0;
                        lru.push_back(f);
                        e_slot = f; e_fence = 1; e_prog = 1;
                    end else begin
                        v = -1;
                        foreach (lru[k]) if (v < 0 && m_pin[lru[k]] == 0) v = lru[k];
                        if (v >= 0) begin
                            e_tag = "R3";
                            e_evict = 1; e_victim = m_own[v];
                            m_own[v] = obj; m_pin[v] = 0; m_dirty[v] = 0;
                            lru_touch(v);
                            e_slot = v; e_fence = 1; e_prog = 1;
                        end else begin
                            e_tag = "R4";
                            e_code = flip ? 3 : 2;
                        end
                    end
                end
            end
            1: begin
                e_tag = "R7";
                if (h >= 0) begin
                    e_slot = h;
                    if (m_pin[h] != 0) begin e_code = 1; e_fence = 1; end
                    else begin e_prog = 1; m_free(h); end
                end
            end
            2: begin
                e_tag = "R8";
                if (h >= 0) begin
                    e_slot = h; e_fence = 1;
                    if (m_pin[h] == PMAX) e_code = 1;
                    else m_pin[h]++;
                end
            end
            3: begin
                e_tag = "R9";
                if (h >= 0) begin
                    e_slot = h; e_fence = 1;
                    if (m_pin[h] == 0) e_code = 4;
                    else m_pin[h]--;
                end
            end
            4: begin
                e_tag = "R10";
                if (h >= 0) begin e_slot = h; e_fence = 1; m_dirty[h] = 1; end
            end
            default: e_tag = "R1";
        endcase
    endtask

    task automatic check_prev();
        checks++;
        if (!e_valid) begin
            if (rsp_done !== 1'b0) begin
                fails++;
                $display("FAIL R1 idle cycle: done=%b expected 0", rsp_done);
            end
        end else if (rsp_done !== 1'b1 || rsp_code !== 3'(e_code) || rsp_slot !== SW'(e_slot) ||
                     rsp_fence !== 1'(e_fence) || rsp_prog !== 1'(e_prog) ||
                     rsp_evict !== 1'(e_evict) || rsp_victim !== OW'(e_victim)) begin
            fails++;
            $display("FAIL %s actual done=%b code=%0d slot=%0d fence=%b prog=%b evict=%b victim=%0d expected done=1 code=%0d slot=%0d fence=%0d prog=%0d evict=%0d victim=%0d",
                     e_tag, rsp_done, rsp_code, rsp_slot, rsp_fence, rsp_prog, rsp_evict, rsp_victim,
                     e_code, e_slot, e_fence, e_prog, e_evict, e_victim);
        end
    endtask

    task automatic step(bit v, int op, int obj, bit tiled, bit flip);
        @(negedge clk);
        check_prev();
        cmd_valid    = v;
        cmd_op       = 3'(op);
        cmd_obj      = OW'(obj);
        cmd_tiled    = tiled;
        flip_pending = flip;
        e_valid      = v;
        if (v) model(op, obj, tiled, flip);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        e_valid = 0;
        for (int i = 0; i < N; i++) begin m_occ[i] = 0; m_own[i] = 0; m_pin[i] = 0; m_dirty[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, no owned slot, idle, unused opcode
        step(1, 2, 5, 1, 0);
        step(0, 0, 0, 0, 0);
        step(1, 6, 5, 1, 0);
        // R2: fill slots in index order
        step(1, 0, 10, 1, 0);
        step(1, 0, 11, 1, 0);
        step(1, 0, 12, 1, 0);
        step(1, 0, 13, 1, 0);
        // R5: hit refreshes recency
        step(1, 0, 11, 0, 0);
        // R3: evict oldest
        step(1, 0, 20, 1, 0);
        // R3: oldest pinned is skipped
        step(1, 2, 12, 0, 0);
        step(1, 0, 21, 1, 0);
        // R4: everything pinned
        step(1, 2, 11, 0, 0);
        step(1, 2, 20, 0, 0);
        step(1, 2, 21, 0, 0);
        step(1, 0, 30, 1, 0);
        step(1, 0, 30, 1, 1);
        // R7 / R9
        step(1, 1, 12, 0, 0);
        step(1, 3, 12, 0, 0);
        step(1, 3, 12, 0, 0);
        step(1, 1, 12, 0, 0);
        step(1, 1, 12, 0, 0);
        // R6, then R2 into freed slot
        step(1, 0, 40, 0, 0);
        step(1, 0, 40, 1, 0);
        // R10: dirty reprogram and dirty release
        step(1, 4, 40, 0, 0);
        step(1, 0, 40, 1, 0);
        step(1, 0, 40, 1, 0);
        step(1, 4, 40, 0, 0);
        step(1, 0, 40, 0, 0);
        step(1, 4, 77, 0, 0);
        // R8: pin saturation
        for (int k = 0; k < PMAX; k++) step(1, 2, 20, 0, 0);
        step(1, 3, 20, 0, 0);
        step(1, 2, 20, 0, 0);
        step(1, 2, 20, 0, 0);
        // Random pressure
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom % 10);
            step(r != 0, int'($urandom % 6), int'($urandom % 7), ($urandom % 4) != 0, 1'($urandom % 2));
        end
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule